// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a bank of general-purpose pins behind a plain 32-bit register bus. Every pin has one configuration word. The word holds the pin's data value, a 3-bit mode field, a stored alternate-function code, an input-enable bit and a 3-bit interrupt group. In output mode the data bit drives the pin. In every other mode, reading the data bit returns the synchronized level of the pin.

A detector on each pin raises a pending flag when its mode's condition is met. The modes are high level, low level, rising edge, falling edge and either edge. Pending flags are packed 32 to a word in a status window that has one slot per group. Software clears a flag by writing a 1 to it. It acknowledges a whole word by writing back the value it read. A single interrupt output is the OR of all pending flags of pins assigned to group 0.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The configuration word of pin n is at byte offset 4*n. It stores bit 0 (data), bits 3:1 (mode), bits 6:5 (function), bit 9 (input enable) and bits 18:16 (group). All other bits read as 0, and the function field does not affect pin behaviour.
- R2: In mode 1 (output) the pin is driven with the stored data bit and its output enable is 1. In every other mode the output enable is 0.
- R3: Outside mode 1, bit 0 of the configuration word reads back the pin level through a two-flop synchronizer. A change at the pin shows on the second rising clock edge after it.
- R4: With the input enable set, mode 2 keeps the pending flag set while the pin is high, and mode 3 keeps it set while the pin is low.
- R5: With the input enable set, the following modes set the pending flag on the edges listed:
  - mode 4: rising edges only;
  - mode 5: falling edges only;
  - mode 6: both rising and falling edges.
- R6: A pin whose input enable is 0 never sets its pending flag.
- R7: Modes 0, 1 and 7 create no new pending flags. A flag already set stays set until it is cleared.
- R8: The status word at byte offset 0x800 + 64*g + 4*w holds, at bit (n mod 32), the pending flag of each pin n with n/32 = w whose group is g. Writing 1 to a bit clears that flag. Writing 0 leaves it unchanged.
- R9: When a detector event and a clear reach the same flag in the same cycle, the event wins and the flag stays set.
- R10: The interrupt output is 1 exactly when at least one pin in group 0 has its pending flag set. Pending flags of other groups do not affect it.
- R11: After reset, every pin is in mode 7 with all other stored fields 0, and all pending flags are clear. Reads from unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | NPINS | Pin levels, asynchronous to clk |
| pin_out | output | NPINS | Output value for each pin |
| pin_oe | output | NPINS | Output enable for each pin |
| irq | output | 1 | Group-0 interrupt request |

## Verification
Reads are combinational, so a register write can be read back at the falling edge that follows its write edge. A pin change driven at a falling edge appears in the data bit after two rising edges. It appears in the pending flag and on irq after three rising edges. The bench counts these edges explicitly and samples only at falling edges. In the level-interrupt test it also checks that irq is still low after two edges, so that an early or late flag is caught.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    MODE_IN   = 3'd0,
    MODE_OUT  = 3'd1,
    MODE_HI   = 3'd2,
    MODE_LO   = 3'd3,
    MODE_RISE = 3'd4,
    MODE_FALL = 3'd5,
    MODE_ANY  = 3'd6,
    MODE_OFF  = 3'd7
  } pin_mode_e;

  typedef struct packed {
    logic       data;
    pin_mode_e  mode;
    logic [1:0] func;
    logic       ien;
    logic [2:0] grp;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{data: 1'b0, mode: MODE_OFF, func: 2'd0,
                                     ien: 1'b0, grp: 3'd0};

  // Detector condition for one pin: cur is the synchronized level, prev the
  // level one cycle earlier.
  function automatic logic mode_hit(pin_mode_e m, logic cur, logic prev);
    case (m)
      MODE_HI:   return cur;
      MODE_LO:   return !cur;
      MODE_RISE: return cur && !prev;
      MODE_FALL: return !cur && prev;
      MODE_ANY:  return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

  // Readback image of a configuration word; bit 0 is the supplied level.
  function automatic logic [31:0] cfg_word(pin_cfg_t c, logic level);
    logic [31:0] w;
    w        = '0;
    w[0]     = level;
    w[3:1]   = c.mode;
    w[6:5]   = c.func;
    w[9]     = c.ien;
    w[18:16] = c.grp;
    return w;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_evt_pend.sv
module gpio_evt_pend
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pin_mode_e        mode_i [NPINS],
  input  logic [NPINS-1:0] ien_i,
  input  logic [NPINS-1:0] cur_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] evt_o,
  output logic [NPINS-1:0] pend_o
);
  logic [NPINS-1:0] pend_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign evt_o[p] = ien_i[p] && mode_hit(mode_i[p], cur_i[p], prev_i[p]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[p] <= 1'b0;
      else        pend_q[p] <= (pend_q[p] && !clr_i[p]) || evt_o[p];
    end
  end

  assign pend_o = pend_q;

  // R9
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_o) |=> ((pend_q & $past(evt_o)) == $past(evt_o)));

  // R7
  no_spurious_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_o)) == '0));

  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((pend_q & $past(clr_i & ~evt_o)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [11:0]      bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam int NWORDS = (NPINS + 31) / 32;

  pin_cfg_t         cfg_q [NPINS];
  pin_mode_e        mode_v [NPINS];
  logic [NPINS-1:0] ien_v, grp0_v, cur_v, prev_v, clr_v, evt_v, pend_v;

  logic [9:0] cfg_idx;
  logic       cfg_hit, st_hit;
  logic [2:0] st_grp;
  logic [3:0] st_word;
  logic [1:0] unused_lsb;

  assign unused_lsb = bus_addr[1:0];
  assign cfg_idx    = bus_addr[11:2];
  assign cfg_hit    = !bus_addr[11] && (int'(cfg_idx) < NPINS);
  assign st_hit     = bus_addr[11] && (bus_addr[10:9] == 2'b00) && (int'(st_word) < NWORDS);
  assign st_grp     = bus_addr[8:6];
  assign st_word    = bus_addr[5:2];

  // Configuration storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) cfg_q[p] <= CFG_RESET;
    end else if (bus_wr && cfg_hit) begin
      for (int p = 0; p < NPINS; p++) begin
        if (int'(cfg_idx) == p) begin
          cfg_q[p].data <= bus_wdata[0];
          cfg_q[p].mode <= pin_mode_e'(bus_wdata[3:1]);
          cfg_q[p].func <= bus_wdata[6:5];
          cfg_q[p].ien  <= bus_wdata[9];
          cfg_q[p].grp  <= bus_wdata[18:16];
        end
      end
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_cfg
    assign mode_v[p]  = cfg_q[p].mode;
    assign ien_v[p]   = cfg_q[p].ien;
    assign grp0_v[p]  = (cfg_q[p].grp == 3'd0);
    assign pin_oe[p]  = (cfg_q[p].mode == MODE_OUT);
    assign pin_out[p] = cfg_q[p].data;
  end

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pin_in),
    .cur_o  (cur_v),
    .prev_o (prev_v)
  );

  // Write-one-to-clear mask for the addressed group and word
  always_comb begin
    clr_v = '0;
    if (bus_wr && st_hit) begin
      for (int p = 0; p < NPINS; p++) begin
        if ((p / 32 == int'(st_word)) && (cfg_q[p].grp == st_grp))
          clr_v[p] = bus_wdata[p % 32];
      end
    end
  end

  gpio_evt_pend #(.NPINS(NPINS)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_v),
    .ien_i  (ien_v),
    .cur_i  (cur_v),
    .prev_i (prev_v),
    .clr_i  (clr_v),
    .evt_o  (evt_v),
    .pend_o (pend_v)
  );

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (cfg_hit) begin
      for (int p = 0; p < NPINS; p++) begin
        if (int'(cfg_idx) == p)
          bus_rdata = cfg_word(cfg_q[p],
                               (cfg_q[p].mode == MODE_OUT) ? cfg_q[p].data : cur_v[p]);
      end
    end else if (st_hit) begin
      for (int p = 0; p < NPINS; p++) begin
        if ((p / 32 == int'(st_word)) && (cfg_q[p].grp == st_grp))
          bus_rdata[p % 32] = pend_v[p];
      end
    end
  end

  assign irq = |(pend_v & grp0_v);

  // R6
  ien_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_v & ~ien_v) == '0);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v == '0) |-> !irq);
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  localparam int NPINS = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [11:0]      bus_addr = '0;
  logic             bus_wr = 1'b0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [NPINS-1:0] pin_in = '0;
  logic [NPINS-1:0] pin_out, pin_oe;
  logic             irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NPINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {address, write data, expected readback}
  localparam logic [75:0] VEC [6] = '{
    {12'h00C, 32'hFFFF_FFFF, 32'h0007_026E},
    {12'h028, 32'h0000_0003, 32'h0000_0003},
    {12'h0FC, 32'h0005_0261, 32'h0005_0260},
    {12'h080, 32'h0000_0202, 32'h0000_0202},
    {12'h014, 32'h0000_0010, 32'h0000_0000},
    {12'h0A4, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R11 reset state
    rd_chk("R11 cfg pin0 reset", 12'h000, 32'h0000_000E);
    rd_chk("R11 cfg pin63 reset", 12'h0FC, 32'h0000_000E);
    rd_chk("R11 status g0w0 reset", 12'h800, 32'h0);
    rd_chk("R11 status g0w1 reset", 12'h804, 32'h0);
    rd_chk("R11 unmapped read", 12'h400, 32'h0);
    rd_chk("R11 unmapped status word", 12'h808, 32'h0);
    check("R11 irq reset", {31'd0, irq}, 32'd0);
    check("R2 oe reset", pin_oe[31:0], 32'h0);

    // R1 table of writes and readbacks
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd_chk("R1 cfg readback", VEC[i][75:64], VEC[i][31:0]);
    end

    // R2 output drive
    check("R2 pin10 out", {31'd0, pin_out[10]}, 32'd1);
    check("R2 pin10 oe", {31'd0, pin_oe[10]}, 32'd1);
    check("R2 pin3 oe off", {31'd0, pin_oe[3]}, 32'd0);
    check("R2 pin63 oe off", {31'd0, pin_oe[63]}, 32'd0);

    // R3 synchronized input readback, pin 5 in mode 0
    pin_in[5] = 1'b1;
    tick(1);
    rd_chk("R3 one edge not yet", 12'h014, 32'h0);
    tick(1);
    rd_chk("R3 two edges visible", 12'h014, 32'h1);

    // R4 high level on pin 40, group 0
    wr(12'h0A0, 32'h0000_0204);
    pin_in[40] = 1'b1;
    tick(2);
    check("R4 irq after two edges", {31'd0, irq}, 32'd0);
    tick(1);
    check("R4 irq after three edges", {31'd0, irq}, 32'd1);
    rd_chk("R4 status pin40", 12'h804, 32'h0000_0100);
    wr(12'h804, 32'h0000_0100);
    rd_chk("R9 level survives clear", 12'h804, 32'h0000_0100);
    pin_in[40] = 1'b0;
    tick(3);
    wr(12'h804, 32'h0000_0100);
    rd_chk("R8 cleared after level gone", 12'h804, 32'h0);
    check("R10 irq drops", {31'd0, irq}, 32'd0);

    // R4 low level on pin 40
    wr(12'h0A0, 32'h0000_0206);
    tick(3);
    rd_chk("R4 low level sets", 12'h804, 32'h0000_0100);
    wr(12'h0A0, 32'h0000_000E);
    wr(12'h804, 32'h0000_0100);
    rd_chk("R7 off mode clear holds", 12'h804, 32'h0);

    // R5 rising edge on pin 1
    wr(12'h004, 32'h0000_0208);
    pin_in[1] = 1'b1;
    tick(3);
    rd_chk("R5 rise sets", 12'h800, 32'h0000_0002);
    wr(12'h800, 32'h0);
    rd_chk("R8 write zero keeps", 12'h800, 32'h0000_0002);
    wr(12'h800, 32'h0000_0002);
    rd_chk("R8 write one clears", 12'h800, 32'h0);
    pin_in[1] = 1'b0;
    tick(3);
    rd_chk("R5 fall ignored in rise mode", 12'h800, 32'h0);

    // R5 falling edge on pin 2
    wr(12'h008, 32'h0000_020A);
    pin_in[2] = 1'b1;
    tick(3);
    rd_chk("R5 rise ignored in fall mode", 12'h800, 32'h0);
    pin_in[2] = 1'b0;
    tick(3);
    rd_chk("R5 fall sets", 12'h800, 32'h0000_0004);
    wr(12'h800, 32'h0000_0004);

    // R5 either edge on pin 4
    wr(12'h010, 32'h0000_020C);
    pin_in[4] = 1'b1;
    tick(3);
    rd_chk("R5 any-edge rise", 12'h800, 32'h0000_0010);
    wr(12'h800, 32'h0000_0010);
    pin_in[4] = 1'b0;
    tick(3);
    rd_chk("R5 any-edge fall", 12'h800, 32'h0000_0010);
    wr(12'h800, 32'hFFFF_FFFF);
    rd_chk("R8 word cleared", 12'h800, 32'h0);

    // R6 input enable off, pin 6 high-level mode
    wr(12'h018, 32'h0000_0004);
    pin_in[6] = 1'b1;
    tick(3);
    rd_chk("R6 no pending without enable", 12'h800, 32'h0);
    check("R6 irq stays low", {31'd0, irq}, 32'd0);

    // R7 switching to mode 7 keeps an existing flag, blocks new ones
    wr(12'h0A0, 32'h0000_0204);
    pin_in[40] = 1'b1;
    tick(3);
    rd_chk("R7 setup pending", 12'h804, 32'h0000_0100);
    wr(12'h0A0, 32'h0000_020E);
    tick(1);
    rd_chk("R7 pending kept in off mode", 12'h804, 32'h0000_0100);
    wr(12'h804, 32'h0000_0100);
    tick(3);
    rd_chk("R7 no new pending in off mode", 12'h804, 32'h0);
    pin_in[40] = 1'b0;

    // R10 group 1 pin 41 does not drive irq
    wr(12'h0A4, 32'h0001_0204);
    pin_in[41] = 1'b1;
    tick(3);
    rd_chk("R10 group1 status word", 12'h844, 32'h0000_0200);
    rd_chk("R10 group0 word excludes pin41", 12'h804, 32'h0);
    check("R10 irq ignores group1", {31'd0, irq}, 32'd0);
    pin_in[41] = 1'b0;
    tick(3);
    wr(12'h844, 32'h0000_0200);
    rd_chk("R8 group1 clear", 12'h844, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule